// File: doc/BRIEF.md
# Per-Site Fault Unit Array

This block is a row of tiny fault units. Each one sits between the driver of one instrumented signal and that signal's loads. While a unit's enable bit is low, its site passes the original value straight through. While the bit is high, the unit corrupts the site according to a two-bit fault-model code held per site. The enable vector comes from an upstream controller stage that decides when and where faults land. This block holds no selection or timing logic.

There are two kinds of site, chosen per bit by a parameter mask:

- A **wire site** is combinational.
- A **register site** holds a flop that normal logic loads through a per-site load strobe.

On a register site an upset flips the value being stored on the enabled cycle. The error then stays in the flop after the one-cycle trigger has gone, until normal logic writes the flop again. Stuck-at faults only force the visible output for as long as they are enabled. They never disturb the stored state.

Top module: `fault_site_array`

## Requirements
- R1: With its enable bit low, a wire site drives `faulty_o` equal to `orig_i` on every cycle.
- R2: With its enable bit low, a register site's output is the value captured at the last rising edge where its `load_i` bit was high, and it holds that value otherwise.
- R3: Code 2'b00 (stuck-at-0) with the enable bit high drives the site output to 0 for as long as the bit stays high.
- R4: Code 2'b01 (stuck-at-1) with the enable bit high drives the site output to 1 for as long as the bit stays high.
- R5: Code 2'b10 (upset) on a wire site inverts `orig_i` only during the cycle the enable bit is high. The next cycle, with the bit low, passes the data through again.
- R6: Code 2'b10 on a register site stores the inverse of the value the flop would otherwise capture at that edge (`orig_i` if loading, else its held value). The flipped value persists after the enable drops, until the next load.
- R7: A stuck-at fault on a register site leaves the stored value unchanged. When the enable drops, the output shows the register content again.
- R8: Code 2'b11 is reserved and behaves as a pass-through even with the enable bit high.
- R9: Enable bit i and code bits [2i+1:2i] affect only site i, and several sites may be corrupted in the same cycle.
- R10: While `rst_n` is low, and until two rising edges after it rises, every register site holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| orig_i | input | N_SITES | Original value from each site's driver |
| load_i | input | N_SITES | Load strobe for register sites (ignored on wire sites) |
| fault_en_i | input | N_SITES | Per-site fault enable from the controller stage |
| fault_cfg_i | input | 2*N_SITES | Fault-model code per site, bits [2i+1:2i] for site i |
| faulty_o | output | N_SITES | Possibly corrupted value delivered to the site's loads |

## Verification
The hardest situation to reach is an upset on a register site whose flipped value must outlive its one-cycle trigger. The trigger has to land on a cycle with and without a load strobe. It must then be followed by idle cycles, a stuck-at overlay and finally a fresh load. Directed sequences build exactly these orderings on chosen register sites. A long random phase with sparse enables and random load strobes then mixes upsets, stuck-at faults and reserved codes across both site kinds. A bench model tracks every register's stored value to predict each cycle's output.

// File: rtl/fsa_pkg.sv
package fsa_pkg;
  typedef enum logic [1:0] {
    FM_SA0  = 2'b00,
    FM_SA1  = 2'b01,
    FM_FLIP = 2'b10,
    FM_NONE = 2'b11
  } fmodel_e;
endpackage

// File: rtl/fsa_rst_sync.sv
module fsa_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_d;
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/fsa_corrupt.sv
module fsa_corrupt
  import fsa_pkg::*;
(
  input  logic    d_i,
  input  logic    act_i,
  input  fmodel_e model_i,
  output logic    y_o
);
  always_comb begin
    y_o = d_i;
    if (act_i) begin
      unique case (model_i)
        FM_SA0:  y_o = 1'b0;
        FM_SA1:  y_o = 1'b1;
        FM_FLIP: y_o = ~d_i;
        FM_NONE: y_o = d_i;
        default: y_o = d_i;
      endcase
    end
  end
endmodule

// File: rtl/fsa_reg_site.sv
module fsa_reg_site
  import fsa_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    d_i,
  input  logic    load_i,
  input  logic    en_i,
  input  fmodel_e model_i,
  output logic    y_o
);
  logic state_q;
  logic state_d;
  logic upset;
  logic capture_en;
  logic overlay_act;

  assign upset       = en_i && (model_i == FM_FLIP);
  assign capture_en  = load_i || upset;
  assign overlay_act = en_i && (model_i != FM_FLIP);

  always_comb begin
    state_d = load_i ? d_i : state_q;
    if (upset) state_d = ~state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          state_q <= 1'b0;
    else if (capture_en) state_q <= state_d;
  end

  fsa_corrupt u_overlay (
    .d_i     (state_q),
    .act_i   (overlay_act),
    .model_i (model_i),
    .y_o     (y_o)
  );

  // R2
  reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !upset) |=> $stable(state_q));
  // R2
  reg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !upset) |=> (state_q == $past(d_i)));
  // R6
  reg_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upset && !load_i) |=> (state_q != $past(state_q)));
  // R7
  reg_stuck_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && (model_i inside {FM_SA0, FM_SA1}) && !load_i) |=> $stable(state_q));
endmodule

// File: rtl/fault_site_array.sv
module fault_site_array
  import fsa_pkg::*;
#(
  parameter int          N_SITES  = 16,
  parameter logic [15:0] REG_MASK = 16'hFF00
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_SITES-1:0]   orig_i,
  input  logic [N_SITES-1:0]   load_i,
  input  logic [N_SITES-1:0]   fault_en_i,
  input  logic [2*N_SITES-1:0] fault_cfg_i,
  output logic [N_SITES-1:0]   faulty_o
);
  localparam int CFG_W = 2;

  logic rst_sync_n;

  fsa_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar i = 0; i < N_SITES; i++) begin : g_site
    fmodel_e model;
    assign model = fmodel_e'(fault_cfg_i[CFG_W*i +: CFG_W]);

    if (REG_MASK[i % 16]) begin : g_reg
      fsa_reg_site u_site (
        .clk     (clk),
        .rst_n   (rst_sync_n),
        .d_i     (orig_i[i]),
        .load_i  (load_i[i]),
        .en_i    (fault_en_i[i]),
        .model_i (model),
        .y_o     (faulty_o[i])
      );
    end else begin : g_wire
      fsa_corrupt u_site (
        .d_i     (orig_i[i]),
        .act_i   (fault_en_i[i]),
        .model_i (model),
        .y_o     (faulty_o[i])
      );
      // R1
      wire_pass_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
        !fault_en_i[i] |-> (faulty_o[i] == orig_i[i]));
      // R5
      wire_flip_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (fault_en_i[i] && model == FM_FLIP) |-> (faulty_o[i] != orig_i[i]));
    end

    // R3
    sa0_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (fault_en_i[i] && model == FM_SA0) |-> !faulty_o[i]);
    // R4
    sa1_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (fault_en_i[i] && model == FM_SA1) |-> faulty_o[i]);
  end
endmodule

// File: tb/tb_fault_site_array.sv
module tb_fault_site_array;
  localparam int          N    = 16;
  localparam logic [15:0] REGM = 16'hFF00;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [N-1:0]   orig, load, en;
  logic [2*N-1:0] cfg;
  logic [N-1:0]   faulty;

  logic [N-1:0]   st;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fault_site_array dut (
    .clk(clk), .rst_n(rst_n), .orig_i(orig), .load_i(load),
    .fault_en_i(en), .fault_cfg_i(cfg), .faulty_o(faulty)
  );

  function automatic logic [N-1:0] exp_out(logic [N-1:0] d, logic [N-1:0] e,
                                           logic [2*N-1:0] c, logic [N-1:0] s);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) begin
      logic base;
      base = REGM[i] ? s[i] : d[i];
      r[i] = base;
      if (e[i]) begin
        case (c[2*i +: 2])
          2'b00: r[i] = 1'b0;
          2'b01: r[i] = 1'b1;
          2'b10: r[i] = REGM[i] ? base : ~d[i];
          default: r[i] = base;
        endcase
      end
    end
    return r;
  endfunction

  function automatic logic [N-1:0] nxt_state(logic [N-1:0] d, logic [N-1:0] l,
                                             logic [N-1:0] e, logic [2*N-1:0] c,
                                             logic [N-1:0] s);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) begin
      r[i] = l[i] ? d[i] : s[i];
      if (e[i] && c[2*i +: 2] == 2'b10) r[i] = ~r[i];
      if (!REGM[i]) r[i] = 1'b0;
    end
    return r;
  endfunction

  function automatic logic [2*N-1:0] all_cfg(logic [1:0] code);
    logic [2*N-1:0] r;
    for (int i = 0; i < N; i++) r[2*i +: 2] = code;
    return r;
  endfunction

  task automatic check(string tag, logic [N-1:0] exp);
    checks++;
    if (faulty !== exp) begin
      errors++;
      $display("FAIL %s: faulty_o=%h expected=%h", tag, faulty, exp);
    end
  endtask

  // drive at negedge, check, then advance model across the rising edge
  task automatic step(string tag, logic [N-1:0] d, logic [N-1:0] l,
                      logic [N-1:0] e, logic [2*N-1:0] c);
    logic [N-1:0] ns;
    orig = d; load = l; en = e; cfg = c;
    #1;
    check(tag, exp_out(d, e, c, st));
    ns = nxt_state(d, l, e, c, st);
    @(posedge clk);
    st = ns;
    @(negedge clk);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: expected=finish actual=timeout");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; orig = '0; load = '1; en = '0; cfg = '1; st = '0;
    orig = '1;
    @(negedge clk); @(negedge clk);
    // R10: register sites read 0 under reset even with load high
    #1 check("R10 in reset", exp_out(orig, en, cfg, '0));
    rst_n = 1'b1;
    @(posedge clk); #1;
    // R10: internal reset still held one edge after release
    check("R10 after release", exp_out(orig, en, cfg, '0));
    @(negedge clk); @(negedge clk);

    // R2/R1: plain loads and pass-through
    step("R2 load", 16'hA5C3, 16'hFFFF, '0, all_cfg(2'b00));
    step("R2 hold", 16'h5A3C, 16'h0000, '0, all_cfg(2'b00));
    step("R1 pass", 16'h0FF0, 16'h0F00, '0, all_cfg(2'b10));
    // R3 / R4 on all sites
    step("R3 stuck0", 16'hFFFF, 16'h0000, 16'hFFFF, all_cfg(2'b00));
    step("R4 stuck1", 16'h0000, 16'h0000, 16'hFFFF, all_cfg(2'b01));
    // R7: stuck-at on register sites with no load, then release
    step("R7 release", 16'h1234, 16'h0000, '0, all_cfg(2'b01));
    // R8 reserved code acts as pass-through
    step("R8 reserved", 16'h3C3C, 16'h00FF, 16'hFFFF, all_cfg(2'b11));
    // R5 wire upset for one cycle then pass again
    step("R5 flip", 16'h00AA, 16'h0000, 16'h00FF, all_cfg(2'b10));
    step("R5 after", 16'h00AA, 16'h0000, 16'h0000, all_cfg(2'b10));
    // R6 register upset without load, then persistence, then with load
    step("R6 flip hold", 16'h0000, 16'h0000, 16'hFF00, all_cfg(2'b10));
    step("R6 persist", 16'h0000, 16'h0000, 16'h0000, all_cfg(2'b00));
    step("R6 persist2", 16'hFFFF, 16'h0000, 16'h0000, all_cfg(2'b00));
    step("R6 flip load", 16'hF000, 16'hFF00, 16'hFF00, all_cfg(2'b10));
    step("R6 shows", 16'h0000, 16'h0000, 16'h0000, all_cfg(2'b11));
    step("R6 reload", 16'h5500, 16'hFF00, 16'h0000, all_cfg(2'b11));
    // R9 single site and mixed sites
    step("R9 one", 16'hFFFF, 16'h0000, 16'h0010, all_cfg(2'b00));
    step("R9 mix", 16'h0F0F, 16'h0000, 16'h8181, {2'b01, 28'h0, 2'b00});

    for (int k = 0; k < 400; k++) begin
      logic [N-1:0] d, l, e;
      logic [2*N-1:0] c;
      d = N'($urandom);
      l = N'($urandom);
      e = N'($urandom) & N'($urandom);
      c = {$urandom};
      step("R9 random mix", d, l, e, c);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule